// File: doc/BRIEF.md
# Four-Port Mode-Selectable Pin Bank

This block gives a small processor four independent 8-bit general-purpose pin ports on a simple register bus. Every pin has two register bits: one in a per-port setup register and one in a per-port level register. Together they select one of four pin behaviours. A pin can float as a plain input, act as an input with a weak pull-up, drive a solid 0, or drive a solid 1. The block does not model pad cells. It produces per-pin output-enable, output-level and pull-up-enable signals that go to the pads.

Software reads pin levels through a third, read-only address per port. The levels pass through a two-stage synchronizer first. A single write changes any pin's behaviour, with no unlock or staging step. A mask parameter marks which pins are bonded out. Unbonded pins always read as 0 on the level address.

Top module: `gpio_quad_bank`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every setup and level register holds 0x00. As a result, every `pad_oe` and every `pad_pu` bit is 0.
- R2: Port p owns addresses 4p (setup register), 4p+1 (level register) and 4p+2 (pin levels, read-only). Reads of 4p and 4p+1 return the stored register value, not the pin level.
- R3: The mode code of a pin is {setup bit, level bit}. The codes are: 00 = floating input (oe=0, pu=0); 01 = pulled-up input (oe=0, pu=1); 10 = drive 0 (oe=1, out=0); 11 = drive 1 (oe=1, out=1). `pad_out` is 0 for both input codes, and `pad_pu` is 0 for both drive codes.
- R4: A write takes effect at the rising edge that samples `bus_wr`. A read of the same register in the cycle of that write returns the previous value.
- R5: A level change on `pad_in` shows on the pin-level read after the second rising edge, and not after the first.
- R6: A pulled-up input with nothing else driving it reads 1. An external device pulling that pin low makes it read 0.
- R7: A pin in drive mode reads back its driven level on the pin-level address.
- R8: `PRESENT_MASK` (default 0x0FFF_FFFF, so bits 7:4 of port 3 are absent) marks the bonded pins. Absent pins read 0 on the pin-level address. Their `pad_oe`, `pad_out` and `pad_pu` still follow the registers.
- R9: Writes to a pin-level address, to offset 3 of any port, or to addresses at or above 4·NPORTS change no register and no pad output. Reads of offset 3 and of addresses at or above 4·NPORTS return 0x00.
- R10: A write to one port leaves the registers and pad outputs of every other port unchanged.
- R11: Reading any address has no side effect on registers or pad outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | NPORTS·8 | Pad input levels, port p at bits 8p+7:8p |
| pad_oe | output | NPORTS·8 | Per-pin output enable |
| pad_out | output | NPORTS·8 | Per-pin output level |
| pad_pu | output | NPORTS·8 | Per-pin weak pull-up enable |

## Verification
Two functions can fall in the same cycle. One is a register write. The other is a read, either of that same register or of the pin levels that the write is about to change. To provoke this, the bench raises the write strobe and samples `bus_rdata` and the pad outputs before the next edge, and both must still show the old value. It then samples again after the edge and expects the new value. The synchronizer delay is judged the same way: a pad level change must stay invisible after one edge and appear after the second.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        PIN_FLOAT  = 2'b00,
        PIN_PULLUP = 2'b01,
        PIN_DRIVE0 = 2'b10,
        PIN_DRIVE1 = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SEL_SETUP = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_PINS  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;

    // Map the two register bits of one pin to its pad controls.
    function automatic pad_ctl_t mode_to_pad(input logic setup_bit, input logic level_bit);
        pad_ctl_t  c;
        pin_mode_e m;
        m = pin_mode_e'({setup_bit, level_bit});
        c = '0;
        case (m)
            PIN_FLOAT:  c = '{oe: 1'b0, out: 1'b0, pu: 1'b0};
            PIN_PULLUP: c = '{oe: 1'b0, out: 1'b0, pu: 1'b1};
            PIN_DRIVE0: c = '{oe: 1'b1, out: 1'b0, pu: 1'b0};
            PIN_DRIVE1: c = '{oe: 1'b1, out: 1'b1, pu: 1'b0};
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_bank_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORTS-1:0] port_hit,
    output reg_sel_e          sel
);
    localparam int PIDX_W = ADDR_W - 2;

    logic [PIDX_W-1:0] port_num;
    assign port_num = addr[ADDR_W-1:2];
    assign sel      = reg_sel_e'(addr[1:0]);

    for (genvar p = 0; p < NPORTS; p++) begin : g_hit
        assign port_hit[p] = (port_num == PIDX_W'(p));
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_setup,
    input  logic         wr_level,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] setup_q,
    output logic [W-1:0] level_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
            level_q <= '0;
        end else begin
            if (wr_setup) setup_q <= wdata;
            if (wr_level) level_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_bank_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] setup_q,
    input  logic [W-1:0] level_q,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_ctl_t ctl;
        assign ctl    = mode_to_pad(setup_q[i], level_q[i]);
        assign oe[i]  = ctl.oe;
        assign out[i] = ctl.out;
        assign pu[i]  = ctl.pu;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_bank_pkg::*;
#(
    parameter int         W       = PORT_W,
    parameter logic [W-1:0] PRESENT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pins_q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= pad_in;
            stage2 <= stage1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_mask
        if (PRESENT[i]) begin : g_bonded
            assign pins_q[i] = stage2[i];
        end else begin : g_absent
            assign pins_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_quad_bank.sv
module gpio_quad_bank
    import gpio_bank_pkg::*;
#(
    parameter int                       NPORTS       = 4,
    parameter int                       ADDR_W       = 5,
    parameter logic [NPORTS*PORT_W-1:0] PRESENT_MASK = 32'h0FFF_FFFF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [PORT_W-1:0]          bus_wdata,
    output logic [PORT_W-1:0]          bus_rdata,
    input  logic [NPORTS*PORT_W-1:0]   pad_in,
    output logic [NPORTS*PORT_W-1:0]   pad_oe,
    output logic [NPORTS*PORT_W-1:0]   pad_out,
    output logic [NPORTS*PORT_W-1:0]   pad_pu
);
    logic [NPORTS-1:0] port_hit;
    reg_sel_e          sel;

    logic [PORT_W-1:0] setup_q [NPORTS];
    logic [PORT_W-1:0] level_q [NPORTS];
    logic [PORT_W-1:0] pins_q  [NPORTS];

    gpio_bus_decode #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .port_hit (port_hit),
        .sel      (sel)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic wr_setup;
        logic wr_level;
        assign wr_setup = bus_wr && port_hit[p] && (sel == SEL_SETUP);
        assign wr_level = bus_wr && port_hit[p] && (sel == SEL_LEVEL);

        gpio_port_regs #(.W(PORT_W)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_setup (wr_setup),
            .wr_level (wr_level),
            .wdata    (bus_wdata),
            .setup_q  (setup_q[p]),
            .level_q  (level_q[p])
        );

        gpio_pin_decode #(.W(PORT_W)) u_mode (
            .setup_q (setup_q[p]),
            .level_q (level_q[p]),
            .oe      (pad_oe [p*PORT_W +: PORT_W]),
            .out     (pad_out[p*PORT_W +: PORT_W]),
            .pu      (pad_pu [p*PORT_W +: PORT_W])
        );

        gpio_in_sync #(.W(PORT_W), .PRESENT(PRESENT_MASK[p*PORT_W +: PORT_W])) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pad_in (pad_in[p*PORT_W +: PORT_W]),
            .pins_q (pins_q[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (port_hit[p]) begin
                case (sel)
                    SEL_SETUP: bus_rdata = setup_q[p];
                    SEL_LEVEL: bus_rdata = level_q[p];
                    SEL_PINS:  bus_rdata = pins_q[p];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int                       NPORTS       = 4,
    parameter int                       ADDR_W       = 5,
    parameter logic [NPORTS*PORT_W-1:0] PRESENT_MASK = 32'h0FFF_FFFF
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic [PORT_W-1:0]        bus_wdata,
    input logic [PORT_W-1:0]        bus_rdata,
    input logic [NPORTS*PORT_W-1:0] pad_in,
    input logic [NPORTS*PORT_W-1:0] pad_oe,
    input logic [NPORTS*PORT_W-1:0] pad_out,
    input logic [NPORTS*PORT_W-1:0] pad_pu
);
    int          pidx;
    logic        in_range;
    logic [1:0]  offs;
    logic [PORT_W-1:0] mask8;
    logic [1:0]  since_rst;

    always_comb begin
        pidx     = int'(bus_addr[ADDR_W-1:2]);
        in_range = (pidx < NPORTS);
        offs     = bus_addr[1:0];
        mask8    = PORT_W'(PRESENT_MASK >> (PORT_W * pidx));
    end

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: reset clears every enable
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_pu == '0));

    // R3 / R4: a setup write sets the output enables of that port at the next edge
    assert_setup_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_range && offs == 2'd0) |=>
        (PORT_W'(pad_oe >> (PORT_W * $past(pidx))) == $past(bus_wdata)));

    // R3 / R4: a level write drives the level onto output pins only
    assert_level_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_range && offs == 2'd1) |=>
        (PORT_W'(pad_out >> (PORT_W * $past(pidx))) ==
         ($past(bus_wdata) & PORT_W'(pad_oe >> (PORT_W * $past(pidx))))));

    // R11: without a write the pad controls hold
    assert_read_no_effect_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    // R9: writes to the pin-level address are ignored
    assert_pin_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && offs == 2'd2) |=>
        ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    // R9: undecoded reads return zero
    assert_undecoded_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_range || offs == 2'd3) |-> (bus_rdata == '0));

    // R5 / R8: pin-level read equals the masked pad value two edges back
    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && in_range && offs == 2'd2) |->
        (bus_rdata == (PORT_W'($past(pad_in, 2) >> (PORT_W * pidx)) & mask8)));
endmodule

bind gpio_quad_bank gpio_bank_checker #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .PRESENT_MASK(PRESENT_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu)
);

// File: tb/gpio_quad_bank_test.sv
`timescale 1ns/1ps
module gpio_quad_bank_test;
    localparam int NP = 4;
    localparam int AW = 5;
    localparam int PW = NP * 8;
    localparam logic [PW-1:0] MASK = 32'h0FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [PW-1:0] pad_in;
    logic [PW-1:0] pad_oe, pad_out, pad_pu;
    logic [PW-1:0] ext_en = '0;
    logic [PW-1:0] ext_val = '0;

    logic [7:0] m_setup [NP];
    logic [7:0] m_level [NP];

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // pad model: driver wins, then external device, then pull-up, else floats low
    always_comb begin
        for (int i = 0; i < PW; i++)
            pad_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);
    end

    gpio_quad_bank #(.NPORTS(NP), .ADDR_W(AW), .PRESENT_MASK(MASK)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (int'(a[AW-1:2]) < NP) begin
            if (a[1:0] == 2'd0) m_setup[a[AW-1:2]] = d;
            if (a[1:0] == 2'd1) m_level[a[AW-1:2]] = d;
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #0.5 v = bus_rdata;
    endtask

    task automatic check_all_regs(input string req);
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            rd(AW'(4*p), v);     chk(req, 32'(v), 32'(m_setup[p]));
            rd(AW'(4*p + 1), v); chk(req, 32'(v), 32'(m_level[p]));
        end
    endtask

    task automatic t_reset;
        for (int p = 0; p < NP; p++) begin m_setup[p] = '0; m_level[p] = '0; end
        check_all_regs("R1 regs after reset");
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_pu", pad_pu, '0);
    endtask

    task automatic t_modes;
        logic [7:0] v;
        wr(5'd8, 8'hF0);
        wr(5'd9, 8'hAA);
        chk("R3 oe port2", 32'(pad_oe[23:16]), 32'hF0);
        chk("R3 out port2", 32'(pad_out[23:16]), 32'hA0);
        chk("R3 pu port2", 32'(pad_pu[23:16]), 32'h0A);
        rd(5'd8, v); chk("R2 setup readback", 32'(v), 32'hF0);
        rd(5'd9, v); chk("R2 level readback", 32'(v), 32'hAA);
        repeat (3) @(negedge clk);
        rd(5'd10, v); chk("R7 R6 pin read port2", 32'(v), 32'hAA);
        ext_en[17] = 1'b1; ext_val[17] = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'd10, v); chk("R6 external low beats pull-up", 32'(v), 32'hA8);
        ext_en[17] = 1'b0;
        wr(5'd8, 8'hF1);
        chk("R11 single write to drive0: oe", 32'(pad_oe[23:16]), 32'hF1);
        chk("R11 single write: pu off", 32'(pad_pu[23:16]), 32'h0A);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        bus_addr = 5'd4; bus_wdata = 8'h0F; bus_wr = 1'b1;
        #0.5;
        chk("R4 read during write old value", 32'(bus_rdata), 32'h00);
        chk("R4 oe before edge", 32'(pad_oe[15:8]), 32'h00);
        @(negedge clk);
        bus_wr = 1'b0;
        m_setup[1] = 8'h0F;
        #0.5;
        chk("R4 read after edge new value", 32'(bus_rdata), 32'h0F);
        chk("R4 oe after edge", 32'(pad_oe[15:8]), 32'h0F);
        chk("R3 drive0 out low", 32'(pad_out[15:8]), 32'h00);
    endtask

    task automatic t_sync;
        ext_en[7:0] = 8'hFF; ext_val[7:0] = 8'h00;
        repeat (3) @(negedge clk);
        bus_addr = 5'd2;
        ext_val[7:0] = 8'h3C;
        @(negedge clk); #0.5;
        chk("R5 one edge still old", 32'(bus_rdata), 32'h00);
        @(negedge clk); #0.5;
        chk("R5 two edges new", 32'(bus_rdata), 32'h3C);
        ext_en[7:0] = 8'h00;
    endtask

    task automatic t_absent;
        logic [7:0] v;
        wr(5'd12, 8'h00);
        wr(5'd13, 8'hFF);
        chk("R8 absent pins still pulled", 32'(pad_pu[31:24]), 32'hFF);
        repeat (3) @(negedge clk);
        rd(5'd14, v); chk("R8 absent pins read 0", 32'(v), 32'h0F);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        logic [PW-1:0] s_oe, s_out, s_pu;
        s_oe = pad_oe; s_out = pad_out; s_pu = pad_pu;
        wr(5'd2, 8'h55);
        wr(5'd6, 8'hAA);
        wr(5'd3, 8'hFF);
        wr(5'd20, 8'hFF);
        wr(5'd31, 8'hFF);
        check_all_regs("R9 regs after ignored writes");
        chk("R9 oe unchanged", pad_oe, s_oe);
        chk("R9 out unchanged", pad_out, s_out);
        chk("R9 pu unchanged", pad_pu, s_pu);
        rd(5'd3, v);  chk("R9 offset 3 reads 0", 32'(v), 32'h00);
        rd(5'd20, v); chk("R9 out of range reads 0", 32'(v), 32'h00);
        rd(5'd9, v); rd(5'd14, v);
        chk("R11 reads leave oe", pad_oe, s_oe);
    endtask

    task automatic t_independent;
        logic [PW-1:0] s_oe;
        s_oe = pad_oe;
        wr(5'd0, 8'hFF);
        wr(5'd1, 8'h55);
        chk("R10 port0 out", 32'(pad_out[7:0]), 32'h55);
        chk("R10 other ports oe", 32'(pad_oe[31:8]), 32'(s_oe[31:8]));
        check_all_regs("R10 other ports regs");
    endtask

    logic done = 1'b0;

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_modes();
        t_same_cycle();
        t_sync();
        t_absent();
        t_ignored();
        t_independent();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule